// File: doc/BRIEF.md
# Per-Instruction Constant-Stride Prefetcher

This block watches the stream of load accesses leaving a core, each tagged with the instruction pointer (IP) of the load and the cache-line address it touched. It keeps a small direct-mapped table indexed by low IP bits. For each load instruction the table learns one fixed distance, measured in cache lines, between that instruction's consecutive accesses. Once the same distance has been seen often enough, each later access from that instruction produces a burst of prefetch line addresses further along the stride.

Distances are measured from a page number and a line offset inside a 4KB page. An access in the same page or in either adjacent page can therefore train the entry, and a stream that crosses a page boundary keeps its confidence. Two instructions that share a table slot are handled with a one-miss grace period. The first foreign access only marks the resident entry as stale. A second foreign access in a row takes the slot over, and the resident instruction can reclaim it if it returns before that happens.

Each access takes one clock. The table is read and rewritten on the same edge, and the prefetch addresses appear on registered outputs in the cycle after the access.

Top module: `ipstride_pf`

## Requirements
- R1: After reset no prefetch output is valid, every table entry is unallocated, and the first access to any IP issues no prefetch.
- R2: The table slot is chosen by the low log2(DEPTH) IP bits (bits 5:0 at the default depth). The tag is the next TAG_W bits (bits 15:6 by default). IP bits above those are ignored.
- R3: A line address splits into a page number (bits above bit 5) and an in-page line offset (bits 5:0). When an access lands in the stored page, the observed stride is the new offset minus the stored offset.
- R4: When the page number is the stored page plus one, the observed stride is 64 plus the offset difference. When it is the stored page minus one, the stride is the offset difference minus 64. An observed stride outside the 7-bit signed range -64..63 does not train the entry.
- R5: An access whose page differs from the stored page by more than one updates the stored page and offset only. It leaves the stride and confidence unchanged and issues no prefetch.
- R6: Confidence is a 2-bit saturating counter. It rises when the observed stride equals the stored stride and falls otherwise. The stored stride is replaced by the observed one only when confidence is 0.
- R7: When confidence after the update is at least 2, the block presents DEGREE (default 3) prefetches one cycle after the access. Slot k (k = 0..DEGREE-1) holds the access line plus (k+1) times the stored stride, and every pf_valid bit is set.
- R8: An access whose tag differs from a valid entry clears only that entry's valid bit and issues no prefetch. The resident instruction keeps its stride and confidence if it returns next.
- R9: An access whose tag differs from an entry that is not valid takes over the entry with the new tag, its page and offset, a stride of 0 and a confidence of 0, and issues no prefetch.
- R10: A repeated access to the same line (observed stride 0) does not train and issues no prefetch.
- R11: In a cycle after one without an access, pf_valid is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_ip | input | IP_W | Instruction pointer of the load |
| acc_line | input | ADDR_W | Cache-line address of the access |
| pf_valid | output | DEGREE | One bit per prefetch slot |
| pf_line | output | DEGREE*ADDR_W | Prefetch line addresses, slot k at bits k*ADDR_W upward |

## Verification
Streams with small positive strides inside one page establish the training sequence: allocate, load the stride, then build confidence, with the first prefetch on the fourth access. Positive and negative streams that cross a page edge show whether the adjacent-page arithmetic is right. A far jump and a plus-one-page step of 64 lines separate "update the page only" from "train with a wrong stride". Interleaved accesses from two aliasing instructions separate the stale-mark step from the takeover step, because the resident stream keeps prefetching after one foreign access, while the newcomer has to start from zero confidence. Repeated lines, idle cycles and IPs that differ only in their high bits complete the set.

// File: rtl/ipstride_pkg.sv
package ipstride_pkg;

   // What one access does to the slot it indexes.
   typedef enum logic [1:0] {
      ACT_IDLE     = 2'd0,
      ACT_STALE    = 2'd1,
      ACT_TAKEOVER = 2'd2,
      ACT_HIT      = 2'd3
   } slot_act_e;

   // Saturating step of an unsigned counter of up to 8 bits.
   function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                           input logic       up,
                                           input logic [7:0] top);
      if (up)
         return (cur == top) ? cur : cur + 8'd1;
      else
         return (cur == 8'd0) ? cur : cur - 8'd1;
   endfunction

endpackage

// File: rtl/ipstride_delta.sv
module ipstride_delta #(
   parameter int PAGE_W   = 30,
   parameter int OFF_W    = 6,
   parameter int STRIDE_W = 7
) (
   input  logic [PAGE_W-1:0]   new_page,
   input  logic [OFF_W-1:0]    new_off,
   input  logic [PAGE_W-1:0]   old_page,
   input  logic [OFF_W-1:0]    old_off,
   output logic                page_near,
   output logic                usable,
   output logic [STRIDE_W-1:0] stride
);
   localparam int SW     = OFF_W + 3;
   localparam int S_LO   = -(1 << (STRIDE_W - 1));
   localparam int S_HI   = (1 << (STRIDE_W - 1)) - 1;
   localparam logic signed [SW-1:0] PG_SPAN = SW'(1 << OFF_W);

   logic [PAGE_W-1:0]     pdiff;
   logic                  same_pg, next_pg, prev_pg;
   logic signed [SW-1:0]  in_pg, raw;
   int                    rv;

   always_comb begin
      pdiff   = new_page - old_page;
      same_pg = (pdiff == '0);
      next_pg = (pdiff == PAGE_W'(1));
      prev_pg = (pdiff == '1);
      in_pg   = $signed(SW'(new_off)) - $signed(SW'(old_off));
      if (next_pg)
         raw = in_pg + PG_SPAN;
      else if (prev_pg)
         raw = in_pg - PG_SPAN;
      else
         raw = in_pg;
      rv        = int'(raw);
      page_near = same_pg | next_pg | prev_pg;
      usable    = page_near && (rv >= S_LO) && (rv <= S_HI) && (rv != 0);
      stride    = rv[STRIDE_W-1:0];
   end

endmodule

// File: rtl/ipstride_table.sv
module ipstride_table
   import ipstride_pkg::*;
#(
   parameter int DEPTH    = 64,
   parameter int TAG_W    = 10,
   parameter int PAGE_W   = 30,
   parameter int OFF_W    = 6,
   parameter int STRIDE_W = 7,
   parameter int CONF_W   = 2,
   parameter int CONF_MIN = 2,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic [IDX_W-1:0]    idx,
   input  logic [TAG_W-1:0]    tag,
   input  logic [PAGE_W-1:0]   page,
   input  logic [OFF_W-1:0]    off,
   output logic                fire,
   output logic [STRIDE_W-1:0] fire_stride
);
   localparam logic [CONF_W-1:0] CONF_TOP = '1;

   logic                vld_q   [DEPTH];
   logic [TAG_W-1:0]    tag_q   [DEPTH];
   logic [PAGE_W-1:0]   page_q  [DEPTH];
   logic [OFF_W-1:0]    off_q   [DEPTH];
   logic [STRIDE_W-1:0] str_q   [DEPTH];
   logic [CONF_W-1:0]   conf_q  [DEPTH];

   logic                r_vld;
   logic [TAG_W-1:0]    r_tag;
   logic [PAGE_W-1:0]   r_page;
   logic [OFF_W-1:0]    r_off;
   logic [STRIDE_W-1:0] r_str;
   logic [CONF_W-1:0]   r_conf;

   logic                near, usable;
   logic [STRIDE_W-1:0] seen_str;
   slot_act_e           act;
   logic                str_match;
   logic [STRIDE_W-1:0] str_n;
   logic [CONF_W-1:0]   conf_n;
   logic [7:0]          conf_step;

   assign r_vld  = vld_q[idx];
   assign r_tag  = tag_q[idx];
   assign r_page = page_q[idx];
   assign r_off  = off_q[idx];
   assign r_str  = str_q[idx];
   assign r_conf = conf_q[idx];

   ipstride_delta #(
      .PAGE_W   (PAGE_W),
      .OFF_W    (OFF_W),
      .STRIDE_W (STRIDE_W)
   ) u_delta (
      .new_page  (page),
      .new_off   (off),
      .old_page  (r_page),
      .old_off   (r_off),
      .page_near (near),
      .usable    (usable),
      .stride    (seen_str)
   );

   always_comb begin
      if (!acc_valid)
         act = ACT_IDLE;
      else if (r_tag == tag)
         act = ACT_HIT;
      else if (r_vld)
         act = ACT_STALE;
      else
         act = ACT_TAKEOVER;

      str_match = (seen_str == r_str);
      conf_step = sat_step(8'(r_conf), str_match, 8'(CONF_TOP));
      conf_n    = r_conf;
      str_n     = r_str;
      if (act == ACT_HIT && usable) begin
         conf_n = conf_step[CONF_W-1:0];
         if (!str_match && r_conf == '0)
            str_n = seen_str;
      end
   end

   assign fire        = (act == ACT_HIT) && usable && (conf_n >= CONF_W'(CONF_MIN));
   assign fire_stride = str_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            vld_q[i]  <= 1'b0;
            tag_q[i]  <= '0;
            page_q[i] <= '0;
            off_q[i]  <= '0;
            str_q[i]  <= '0;
            conf_q[i] <= '0;
         end
      end else begin
         unique case (act)
            ACT_STALE: begin
               vld_q[idx] <= 1'b0;
            end
            ACT_TAKEOVER: begin
               vld_q[idx]  <= 1'b1;
               tag_q[idx]  <= tag;
               page_q[idx] <= page;
               off_q[idx]  <= off;
               str_q[idx]  <= '0;
               conf_q[idx] <= '0;
            end
            ACT_HIT: begin
               vld_q[idx]  <= 1'b1;
               page_q[idx] <= page;
               off_q[idx]  <= off;
               str_q[idx]  <= str_n;
               conf_q[idx] <= conf_n;
            end
            default: ;
         endcase
      end
   end

   // near is folded into usable; kept visible for the unused check.
   logic near_unused;
   assign near_unused = near;

endmodule

// File: rtl/ipstride_issue.sv
module ipstride_issue #(
   parameter int ADDR_W   = 36,
   parameter int STRIDE_W = 7,
   parameter int DEGREE   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fire,
   input  logic [ADDR_W-1:0]        base,
   input  logic [STRIDE_W-1:0]      stride,
   output logic [DEGREE-1:0]        pf_valid,
   output logic [DEGREE*ADDR_W-1:0] pf_line
);
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] cand [DEGREE];

   assign step = {{(ADDR_W-STRIDE_W){stride[STRIDE_W-1]}}, stride};

   for (genvar k = 0; k < DEGREE; k++) begin : g_slot
      if (k == 0) begin : g_first
         assign cand[k] = base + step;
      end else begin : g_chain
         assign cand[k] = cand[k-1] + step;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pf_valid[k]                 <= 1'b0;
            pf_line[k*ADDR_W +: ADDR_W] <= '0;
         end else begin
            pf_valid[k] <= fire;
            if (fire)
               pf_line[k*ADDR_W +: ADDR_W] <= cand[k];
         end
      end
   end

endmodule

// File: rtl/ipstride_pf.sv
module ipstride_pf #(
   parameter int IP_W     = 32,
   parameter int ADDR_W   = 36,
   parameter int DEPTH    = 64,
   parameter int TAG_W    = 10,
   parameter int OFF_W    = 6,
   parameter int STRIDE_W = 7,
   parameter int CONF_W   = 2,
   parameter int CONF_MIN = 2,
   parameter int DEGREE   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     acc_valid,
   input  logic [IP_W-1:0]          acc_ip,
   input  logic [ADDR_W-1:0]        acc_line,
   output logic [DEGREE-1:0]        pf_valid,
   output logic [DEGREE*ADDR_W-1:0] pf_line
);
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int PAGE_W = ADDR_W - OFF_W;
   localparam int IP_USE = IDX_W + TAG_W;

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("ipstride_pf: DEPTH must be a power of two of at least 2");
   end
   if (IP_USE > IP_W) begin : g_bad_tag
      $error("ipstride_pf: index plus tag wider than the IP");
   end
   if (PAGE_W < 2) begin : g_bad_addr
      $error("ipstride_pf: ADDR_W must leave a page number above the offset");
   end
   if ((STRIDE_W < 2) || (STRIDE_W > OFF_W + 2) || (STRIDE_W > ADDR_W)) begin : g_bad_stride
      $error("ipstride_pf: STRIDE_W out of range");
   end
   if ((CONF_W < 1) || (CONF_W > 8) || (CONF_MIN < 1) || (CONF_MIN >= (1 << CONF_W))) begin : g_bad_conf
      $error("ipstride_pf: confidence width or threshold out of range");
   end
   if (DEGREE < 1) begin : g_bad_degree
      $error("ipstride_pf: DEGREE must be at least 1");
   end

   if (IP_W > IP_USE) begin : g_ip_hi
      logic ip_hi_unused;
      assign ip_hi_unused = ^acc_ip[IP_W-1:IP_USE];
   end

   logic                fire;
   logic [STRIDE_W-1:0] fire_stride;

   ipstride_table #(
      .DEPTH    (DEPTH),
      .TAG_W    (TAG_W),
      .PAGE_W   (PAGE_W),
      .OFF_W    (OFF_W),
      .STRIDE_W (STRIDE_W),
      .CONF_W   (CONF_W),
      .CONF_MIN (CONF_MIN)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_valid   (acc_valid),
      .idx         (acc_ip[IDX_W-1:0]),
      .tag         (acc_ip[IDX_W +: TAG_W]),
      .page        (acc_line[ADDR_W-1:OFF_W]),
      .off         (acc_line[OFF_W-1:0]),
      .fire        (fire),
      .fire_stride (fire_stride)
   );

   ipstride_issue #(
      .ADDR_W   (ADDR_W),
      .STRIDE_W (STRIDE_W),
      .DEGREE   (DEGREE)
   ) u_issue (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .base     (acc_line),
      .stride   (fire_stride),
      .pf_valid (pf_valid),
      .pf_line  (pf_line)
   );

endmodule

// File: rtl/ipstride_pf_chk.sv
module ipstride_pf_chk #(
   parameter int ADDR_W   = 36,
   parameter int STRIDE_W = 7,
   parameter int DEGREE   = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     acc_valid,
   input logic [ADDR_W-1:0]        acc_line,
   input logic [DEGREE-1:0]        pf_valid,
   input logic [DEGREE*ADDR_W-1:0] pf_line
);
   localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (STRIDE_W - 1);
   localparam logic [ADDR_W-1:0] FULL = ADDR_W'(1) << STRIDE_W;

   logic [ADDR_W-1:0] prev_line;
   logic [ADDR_W-1:0] first_step;

   always_ff @(posedge clk) prev_line <= acc_line;
   assign first_step = pf_line[ADDR_W-1:0] - prev_line;

   AST_PF_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid != '0) |-> $past(acc_valid)); // R11

   AST_SLOTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid == '0) || (&pf_valid)); // R7

   AST_NONZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid[0] |-> (first_step != '0)); // R10

   AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid[0] |-> ((first_step + HALF) < FULL)); // R4

   for (genvar k = 1; k < DEGREE; k++) begin : g_space
      AST_EVEN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
         pf_valid[k] |-> ((pf_line[k*ADDR_W +: ADDR_W] - pf_line[(k-1)*ADDR_W +: ADDR_W]) == first_step)); // R7
   end

endmodule

bind ipstride_pf ipstride_pf_chk #(
   .ADDR_W   (ADDR_W),
   .STRIDE_W (STRIDE_W),
   .DEGREE   (DEGREE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_line  (acc_line),
   .pf_valid  (pf_valid),
   .pf_line   (pf_line)
);

// File: tb/ipstride_pf_test.sv
`timescale 1ns/1ps
module ipstride_pf_test;
   localparam int IP_W   = 32;
   localparam int ADDR_W = 36;
   localparam int DEGREE = 3;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     acc_valid = 1'b0;
   logic [IP_W-1:0]          acc_ip = '0;
   logic [ADDR_W-1:0]        acc_line = '0;
   logic [DEGREE-1:0]        pf_valid;
   logic [DEGREE*ADDR_W-1:0] pf_line;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ipstride_pf uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_ip    (acc_ip),
      .acc_line  (acc_line),
      .pf_valid  (pf_valid),
      .pf_line   (pf_line)
   );

   function automatic logic [IP_W-1:0] mk_ip(input int tag, input int idx);
      return IP_W'((tag << 6) | idx);
   endfunction

   // One access; returns just after the capturing edge with the input dropped.
   task automatic access(input logic [IP_W-1:0] ip, input logic [ADDR_W-1:0] line);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_ip    = ip;
      acc_line  = line;
      @(posedge clk);
      #1;
      acc_valid = 1'b0;
   endtask

   task automatic expect_none(input string req);
      total++;
      if (pf_valid !== '0) begin
         bad++;
         $display("FAIL %s: pf_valid=%b expected=000", req, pf_valid);
      end
   endtask

   task automatic expect_pf(input string req, input logic [ADDR_W-1:0] base, input int stride);
      total++;
      if (pf_valid !== '1) begin
         bad++;
         $display("FAIL %s: pf_valid=%b expected=111", req, pf_valid);
      end else begin
         for (int k = 0; k < DEGREE; k++) begin
            logic [ADDR_W-1:0] exp_a;
            exp_a = base + ADDR_W'((k + 1) * stride);
            if (pf_line[k*ADDR_W +: ADDR_W] !== exp_a) begin
               bad++;
               $display("FAIL %s: slot%0d=%h expected=%h", req, k,
                        pf_line[k*ADDR_W +: ADDR_W], exp_a);
            end
         end
      end
   endtask

   task automatic t_reset;
      expect_none("R1 reset");
      access(mk_ip(0, 0), 36'h0);
      expect_none("R1 first access");
   endtask

   task automatic t_same_page;
      logic [IP_W-1:0] ip = mk_ip(1, 1);
      access(ip, 36'h4000); expect_none("R6 allocate");
      access(ip, 36'h4002); expect_none("R6 load stride");
      access(ip, 36'h4004); expect_none("R6 conf1");
      access(ip, 36'h4006); expect_pf("R3 R7 conf2", 36'h4006, 2);
      access(ip, 36'h4008); expect_pf("R7 conf3", 36'h4008, 2);
   endtask

   task automatic t_cross_page;
      logic [IP_W-1:0] ipa = mk_ip(1, 2);
      logic [IP_W-1:0] ipb = mk_ip(1, 3);
      access(ipa, 36'h403C); access(ipa, 36'h403F);
      access(ipa, 36'h4042); expect_none("R4 up conf1");
      access(ipa, 36'h4045); expect_pf("R4 up page", 36'h4045, 3);
      access(ipb, 36'h8006); access(ipb, 36'h8001);
      access(ipb, 36'h7FFC); expect_none("R4 down conf1");
      access(ipb, 36'h7FF7); expect_pf("R4 down page", 36'h7FF7, -5);
   endtask

   task automatic t_far_and_wide;
      logic [IP_W-1:0] ipc = mk_ip(1, 4);
      logic [IP_W-1:0] ipd = mk_ip(1, 5);
      access(ipc, 36'hA000); access(ipc, 36'hA001); access(ipc, 36'hA002);
      access(ipc, 36'hA003); expect_pf("R5 trained", 36'hA003, 1);
      access(ipc, 36'hC000); expect_none("R5 far jump");
      access(ipc, 36'hC001); expect_pf("R5 page kept", 36'hC001, 1);
      access(ipd, 36'h1003C); access(ipd, 36'h1003D); access(ipd, 36'h1003E);
      access(ipd, 36'h1003F); expect_pf("R4 trained", 36'h1003F, 1);
      access(ipd, 36'h1007F); expect_none("R4 stride 64 rejected");
      access(ipd, 36'h10080); expect_pf("R4 conf intact", 36'h10080, 1);
   endtask

   task automatic t_alias;
      logic [IP_W-1:0] ia = mk_ip(2, 6);
      logic [IP_W-1:0] ib = mk_ip(3, 6);
      access(ia, 36'h2000); access(ia, 36'h2004); access(ia, 36'h2008);
      access(ia, 36'h200C); expect_pf("R8 trained", 36'h200C, 4);
      access(ib, 36'h9000); expect_none("R8 stale mark");
      access(ia, 36'h2010); expect_pf("R8 resident kept", 36'h2010, 4);
      access(ib, 36'h9000); expect_none("R8 stale again");
      access(ib, 36'h9001); expect_none("R9 takeover");
      access(ib, 36'h9002); expect_none("R9 load stride");
      access(ib, 36'h9003); expect_none("R9 conf restarted");
      access(ib, 36'h9004); expect_pf("R9 new owner", 36'h9004, 1);
      access(ia, 36'h2014); expect_none("R9 old owner lost");
   endtask

   task automatic t_repeat_idle;
      logic [IP_W-1:0] ip = mk_ip(1, 7);
      access(ip, 36'h5000); access(ip, 36'h5002); access(ip, 36'h5004);
      access(ip, 36'h5006); expect_pf("R10 trained", 36'h5006, 2);
      access(ip, 36'h5006); expect_none("R10 repeat line");
      access(ip, 36'h5008); expect_pf("R10 conf intact", 36'h5008, 2);
      @(negedge clk); @(negedge clk);
      expect_none("R11 idle");
   endtask

   task automatic t_high_bits;
      access(32'h0001_0048, 36'h6000);
      access(32'h0005_0048, 36'h6003);
      access(32'h8000_0048, 36'h6006);
      access(32'h0100_0048, 36'h6009); expect_pf("R2 high bits ignored", 36'h6009, 3);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_same_page();
      t_cross_page();
      t_far_and_wide();
      t_alias();
      t_repeat_idle();
      t_high_bits();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule